// File: doc/BRIEF.md
# Two-Bitmap On-Screen Display Renderer

This block produces a per-pixel overlay key for an on-screen display made of two coarse bitmaps. Both bitmaps share one 256-byte cell memory. Every cell is 2 bits wide and each byte packs four cells. The small bitmap is a 16 by 16 grid of 4x4-pixel cells, which gives a 64x64-pixel area. It lives in the upper quarter of the memory. The wide bitmap is a 48 by 16 grid of 8x8-pixel cells, which gives a 384x128-pixel area. It fills the lower three quarters.

A host loads the memory through a small register set. It first selects the OSD as the write target. Then it writes an index register followed by a data register, as many times as needed. The same register set holds the show bits, the coarse positions and the mesh controls.

During the raster, the block receives one pixel coordinate per clock. It returns the overlay key and a gray flag for that coordinate one clock later. Key 0 lets the video through, and keys 1 to 3 select an overlay colour that is mixed downstream. The optional mesh background fills the transparent parts of a shown bitmap with a pixel checkerboard. The mesh is drawn either in gray or in overlay colour 3.

Top module: `osd_overlay_render`

## Requirements
- R1: After a synchronous active-low reset, osd_key is 0 and osd_gray is 0. All control registers are 0 and every memory byte is 0, so no cell is visible until the memory is loaded.
- R2: The small bitmap covers x in [64*H1, 64*H1+63] and y in [64*V, 64*V+63]. A pixel at offset (dx, dy) from that origin uses cell column dx/4 and cell row dy/4. That cell is held in byte 192 + 4*row + column/4.
- R3: The wide bitmap covers x in [64*H2, 64*H2+383] and y in [64*V, 64*V+127]. A pixel at offset (dx, dy) uses cell column dx/8 and cell row dy/8. That cell is held in byte 12*row + column/4.
- R4: Within a byte, cell column%4 = 0 is held in bits 7:6, column%4 = 1 in bits 5:4, column%4 = 2 in bits 3:2, and column%4 = 3 in bits 1:0.
- R5: A pixel inside a shown bitmap gets its cell code (0..3) as its key. A pixel outside every shown bitmap gets key 0, and so does a pixel whose cells are all 0 with the mesh off.
- R6: Control register (address 0) bit 2 shows the small bitmap and bit 3 shows the wide bitmap. A hidden bitmap contributes neither key nor mesh.
- R7: Where both bitmaps cover a pixel, a non-zero small-bitmap cell wins. A zero small-bitmap cell lets the wide bitmap's cell through.
- R8: A write to the data register (address 2) stores the data byte at the index held in the index register (address 1). This happens only when control bits 1:0 equal 11. With any other target value the write leaves the memory unchanged. The index never changes by itself.
- R9: With the mesh enable (address 5, bit 0) set, a pixel inside a shown bitmap that would otherwise have key 0 is a mesh pixel when x[0] XOR y[0] = 1. If the mesh colour bit (address 5, bit 1) is 0, a mesh pixel gives osd_gray = 1 and key 0. If it is 1, a mesh pixel gives key 3 and osd_gray = 0.
- R10: The key and gray flag for the coordinate presented before a rising clock edge appear right after that edge. They hold until the next edge.
- R11: The small-bitmap start is bits 7:3 of address 3 and the wide-bitmap start is bits 7:3 of address 4. The shared vertical start is bits 7:4 of address 5. The remaining bits of those registers do not move the bitmaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 index, 2 data, 3 small start, 4 wide start, 5 vertical/mesh |
| reg_wdata | input | 8 | Register write data |
| pix_x | input | X_W (11) | Current pixel column |
| pix_y | input | Y_W (10) | Current pixel line |
| osd_key | output | 2 | Overlay key: 0 video, 1..3 overlay colour |
| osd_gray | output | 1 | Paint this pixel gray (mesh) |

## Verification
The bench builds the block with its default widths: an 11-bit column and a 10-bit line. These reach every coarse horizontal and vertical start the position fields can encode. They also reach the first pixel past the right and bottom edge of both bitmaps, so both edges of each bitmap can be probed. With these widths the bench can also move the small bitmap off the wide one and shift both bitmaps down by one vertical step. It uses this to check that the low register bits are ignored and that the two bitmaps keep their own origins.

// File: rtl/osd_pkg.sv
// Shared constants and types for the two-bitmap OSD renderer.
// Assumes a byte-wide cell memory of 256 entries and four 2-bit cells per byte.
package osd_pkg;

    // Register map (host side)
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_INDEX = 3'd1;
    localparam logic [2:0] RA_DATA  = 3'd2;
    localparam logic [2:0] RA_HPOS1 = 3'd3;
    localparam logic [2:0] RA_HPOS2 = 3'd4;
    localparam logic [2:0] RA_VPOS  = 3'd5;

    // Write-target code that routes data writes into the cell memory
    localparam logic [1:0] TGT_OSD = 2'b11;

    // Memory geometry
    localparam int MEM_DEPTH      = 256;
    localparam int MEM_AW         = 8;
    localparam int BYTE_W         = 8;
    localparam int CELLS_PER_BYTE = 4;

    // Coarse position step: 64 pixels / 64 lines
    localparam int POS_STEP_LOG2 = 6;
    localparam int HPOS_W        = 5;
    localparam int VPOS_W        = 4;

    // Small bitmap geometry
    localparam int SB_CELL_LOG2 = 2;
    localparam int SB_COLS      = 16;
    localparam int SB_ROWS      = 16;
    localparam int SB_BASE      = 192;

    // Wide bitmap geometry
    localparam int WB_CELL_LOG2 = 3;
    localparam int WB_COLS      = 48;
    localparam int WB_ROWS      = 16;
    localparam int WB_BASE      = 0;

    localparam int NUM_BM = 2;

    typedef logic [1:0] key_t;

    // Result of locating a pixel inside one bitmap
    typedef struct packed {
        logic       hit;   // pixel inside a shown bitmap
        logic [1:0] slot;  // cell position within its byte (0 = leftmost)
    } cell_ref_t;

    // Extract the 2-bit cell of a byte; slot 0 lives in the top bits
    function automatic key_t pick_cell(input logic [BYTE_W-1:0] b, input logic [1:0] slot);
        key_t k;
        case (slot)
            2'd0:    k = b[7:6];
            2'd1:    k = b[5:4];
            2'd2:    k = b[3:2];
            default: k = b[1:0];
        endcase
        return k;
    endfunction

endpackage

// File: rtl/osd_regs.sv
// Host register file of the OSD renderer.
// Holds the write target, show bits, index, positions and mesh controls,
// and turns data-register writes into cell-memory writes when the OSD is
// the selected target. Assumes one write per cycle and no read-back.
module osd_regs
    import osd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic                 show_sb,
    output logic                 show_wb,
    output logic [HPOS_W-1:0]    hpos_sb,
    output logic [HPOS_W-1:0]    hpos_wb,
    output logic [VPOS_W-1:0]    vpos,
    output logic                 mesh_en,
    output logic                 mesh_c3,
    output logic                 mem_we,
    output logic [MEM_AW-1:0]    mem_waddr,
    output logic [BYTE_W-1:0]    mem_wdata
);

    logic [1:0]        target;
    logic [MEM_AW-1:0] index_q;

    // Capture host writes into the addressed control field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target  <= '0;
            show_sb <= 1'b0;
            show_wb <= 1'b0;
            index_q <= '0;
            hpos_sb <= '0;
            hpos_wb <= '0;
            vpos    <= '0;
            mesh_en <= 1'b0;
            mesh_c3 <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    target  <= reg_wdata[1:0];
                    show_sb <= reg_wdata[2];
                    show_wb <= reg_wdata[3];
                end
                RA_INDEX: index_q <= reg_wdata;
                RA_HPOS1: hpos_sb <= reg_wdata[7:3];
                RA_HPOS2: hpos_wb <= reg_wdata[7:3];
                RA_VPOS: begin
                    vpos    <= reg_wdata[7:4];
                    mesh_c3 <= reg_wdata[1];
                    mesh_en <= reg_wdata[0];
                end
                default: ;
            endcase
        end
    end

    // Route data writes into the cell memory only when the OSD is targeted
    always_comb begin
        mem_we    = reg_we && (reg_addr == RA_DATA) && (target == TGT_OSD);
        mem_waddr = index_q;
        mem_wdata = reg_wdata;
    end

    // R11
    hpos_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_HPOS1) |=> (hpos_sb == $past(reg_wdata[7:3])));

endmodule

// File: rtl/osd_cell_mem.sv
// Cell memory: DEPTH bytes, one write port, NRD synchronous read ports.
// Read data is registered, so an address given in one cycle returns its
// byte after the next edge. Cleared by reset so that all cells start clear.
module osd_cell_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int NRD   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    logic [DW-1:0] mem [DEPTH];

    // Storage array with reset clear and single write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One registered read per port, one port per bitmap
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) rdata[p] <= '0;
            else        rdata[p] <= mem[raddr[p]];
        end
    end

    // R8
    mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/osd_locate.sv
// Maps a pixel coordinate onto one bitmap: tells whether the pixel falls
// inside the shown bitmap, which byte holds its cell and where in the byte
// the cell sits. Pure combinational. Assumes X_W >= 11 and Y_W >= 10 so
// that every coarse start position is representable.
module osd_locate
    import osd_pkg::*;
#(
    parameter int X_W       = 11,
    parameter int Y_W       = 10,
    parameter int CELL_LOG2 = 2,
    parameter int COLS      = 16,
    parameter int ROWS      = 16,
    parameter int BASE      = 192,
    parameter int AW        = 8
) (
    input  logic [X_W-1:0]    pix_x,
    input  logic [Y_W-1:0]    pix_y,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [VPOS_W-1:0] vpos,
    input  logic              show,
    output cell_ref_t         cref,
    output logic [AW-1:0]     byte_addr
);

    localparam int SPAN_X        = COLS << CELL_LOG2;
    localparam int SPAN_Y        = ROWS << CELL_LOG2;
    localparam int BYTES_PER_ROW = COLS / CELLS_PER_BYTE;
    localparam int COL_W         = $clog2(COLS);
    localparam int ROW_W         = $clog2(ROWS);

    logic [X_W-1:0] x0;
    logic [Y_W-1:0] y0;
    logic [X_W:0]   dx_ext;
    logic [Y_W:0]   dy_ext;
    logic [X_W-1:0] dx;
    logic [Y_W-1:0] dy;
    logic           in_x;
    logic           in_y;
    logic [COL_W-1:0] col_idx;
    logic [ROW_W-1:0] row_idx;

    // Origin of the bitmap in pixels, from the coarse start fields
    always_comb begin
        x0 = X_W'({hpos, {POS_STEP_LOG2{1'b0}}});
        y0 = Y_W'({vpos, {POS_STEP_LOG2{1'b0}}});
    end

    // Offset from origin and window test (borrow means left of / above origin)
    always_comb begin
        dx_ext = {1'b0, pix_x} - {1'b0, x0};
        dy_ext = {1'b0, pix_y} - {1'b0, y0};
        dx     = dx_ext[X_W-1:0];
        dy     = dy_ext[Y_W-1:0];
        in_x   = !dx_ext[X_W] && (dx < X_W'(SPAN_X));
        in_y   = !dy_ext[Y_W] && (dy < Y_W'(SPAN_Y));
    end

    // Cell coordinates and the byte that holds the cell
    always_comb begin
        col_idx   = dx[CELL_LOG2 +: COL_W];
        row_idx   = dy[CELL_LOG2 +: ROW_W];
        byte_addr = AW'(BASE) + AW'(row_idx) * AW'(BYTES_PER_ROW) + AW'(col_idx >> 2);
        cref.hit  = show && in_x && in_y;
        cref.slot = col_idx[1:0];
    end

endmodule

// File: rtl/osd_mix.sv
// Combines the two bitmaps' cell codes and the mesh into the final key.
// Priority: small-bitmap non-zero cell, then wide-bitmap non-zero cell,
// then mesh, else transparent. Pure combinational apart from its check.
module osd_mix
    import osd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_sb,
    input  key_t code_sb,
    input  logic hit_wb,
    input  key_t code_wb,
    input  logic mesh_hit,
    input  logic mesh_c3,
    output key_t key,
    output logic gray
);

    key_t eff_sb;
    key_t eff_wb;

    // Mask each bitmap's code by whether the pixel is inside it
    always_comb begin
        eff_sb = hit_sb ? code_sb : 2'd0;
        eff_wb = hit_wb ? code_wb : 2'd0;
    end

    // Priority resolution between bitmaps and mesh
    always_comb begin
        key  = 2'd0;
        gray = 1'b0;
        if (eff_sb != 2'd0) begin
            key = eff_sb;
        end else if (eff_wb != 2'd0) begin
            key = eff_wb;
        end else if (mesh_hit) begin
            if (mesh_c3) key = 2'd3;
            else         gray = 1'b1;
        end
    end

    // R9
    gray_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gray |-> (key == 2'd0));

endmodule

// File: rtl/osd_overlay_render.sv
// Two-bitmap OSD renderer top. One pixel coordinate per clock goes in.
// Both bitmaps are located in parallel and their bytes are read from the
// shared cell memory in the same cycle. The key for that coordinate is
// output after the next edge. Assumes the coordinate is held for at least
// one clock and that colour mixing happens downstream.
module osd_overlay_render
    import osd_pkg::*;
#(
    parameter int X_W = 11,
    parameter int Y_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [2:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    input  logic [X_W-1:0] pix_x,
    input  logic [Y_W-1:0] pix_y,
    output logic [1:0]     osd_key,
    output logic           osd_gray
);

    logic              show_sb, show_wb;
    logic [HPOS_W-1:0] hpos_sb, hpos_wb;
    logic [VPOS_W-1:0] vpos;
    logic              mesh_en, mesh_c3;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;

    logic [HPOS_W-1:0] hpos_arr [NUM_BM];
    logic              show_arr [NUM_BM];
    cell_ref_t         cref     [NUM_BM];
    cell_ref_t         cref_q   [NUM_BM];
    logic [MEM_AW-1:0] raddr    [NUM_BM];
    logic [BYTE_W-1:0] rdata    [NUM_BM];
    key_t              code     [NUM_BM];
    logic              mesh_q;
    logic              mesh_c3_q;
    logic              any_hit;

    osd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .show_sb   (show_sb),
        .show_wb   (show_wb),
        .hpos_sb   (hpos_sb),
        .hpos_wb   (hpos_wb),
        .vpos      (vpos),
        .mesh_en   (mesh_en),
        .mesh_c3   (mesh_c3),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    // Gather per-bitmap controls into arrays indexed like the locators
    always_comb begin
        hpos_arr[0] = hpos_sb;
        hpos_arr[1] = hpos_wb;
        show_arr[0] = show_sb;
        show_arr[1] = show_wb;
    end

    // One locator per bitmap; index 0 is the small bitmap, 1 the wide one
    for (genvar g = 0; g < NUM_BM; g++) begin : g_bm
        localparam int CL   = (g == 0) ? SB_CELL_LOG2 : WB_CELL_LOG2;
        localparam int NC   = (g == 0) ? SB_COLS      : WB_COLS;
        localparam int NR   = (g == 0) ? SB_ROWS      : WB_ROWS;
        localparam int BASE = (g == 0) ? SB_BASE      : WB_BASE;

        osd_locate #(
            .X_W       (X_W),
            .Y_W       (Y_W),
            .CELL_LOG2 (CL),
            .COLS      (NC),
            .ROWS      (NR),
            .BASE      (BASE),
            .AW        (MEM_AW)
        ) u_loc (
            .pix_x     (pix_x),
            .pix_y     (pix_y),
            .hpos      (hpos_arr[g]),
            .vpos      (vpos),
            .show      (show_arr[g]),
            .cref      (cref[g]),
            .byte_addr (raddr[g])
        );

        // Keep hit and slot aligned with the registered memory byte
        always_ff @(posedge clk) begin
            if (!rst_n) cref_q[g] <= '0;
            else        cref_q[g] <= cref[g];
        end

        // Select the addressed cell out of the byte just read
        always_comb code[g] = pick_cell(rdata[g], cref_q[g].slot);
    end

    osd_cell_mem #(
        .DEPTH (MEM_DEPTH),
        .AW    (MEM_AW),
        .DW    (BYTE_W),
        .NRD   (NUM_BM)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    // Mesh candidate: checkerboard pixel inside any shown bitmap
    always_comb any_hit = cref[0].hit || cref[1].hit;

    // Register the mesh decision alongside the memory read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mesh_q    <= 1'b0;
            mesh_c3_q <= 1'b0;
        end else begin
            mesh_q    <= mesh_en && any_hit && (pix_x[0] ^ pix_y[0]);
            mesh_c3_q <= mesh_c3;
        end
    end

    osd_mix u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_sb   (cref_q[0].hit),
        .code_sb  (code[0]),
        .hit_wb   (cref_q[1].hit),
        .code_wb  (code[1]),
        .mesh_hit (mesh_q),
        .mesh_c3  (mesh_c3_q),
        .key      (osd_key),
        .gray     (osd_gray)
    );

    // R6
    hidden_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!show_sb && !show_wb) |=> (osd_key == 2'd0 && !osd_gray));

    // R9
    mesh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mesh_en |=> !osd_gray);

endmodule

// File: tb/test_osd_overlay_render.sv
`timescale 1ns/1ps
module test_osd_overlay_render;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [10:0] pix_x = '0;
    logic [9:0]  pix_y = '0;
    logic [1:0]  osd_key;
    logic        osd_gray;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    osd_overlay_render i_osd_overlay_render (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .osd_key   (osd_key),
        .osd_gray  (osd_gray)
    );

    // Vectors with mesh off, small bitmap at x=64,y=0, wide bitmap at 0,0
    localparam int NV = 22;
    localparam int VX [NV] = '{  0,  8, 16, 24,  7,  3,  8, 64, 68, 72, 76,
                                80, 77, 77,127,128,127,383,384,383, 63, 67};
    localparam int VY [NV] = '{  0,  0,  0,  0,  7,  9,  9,  0,  1,  0,  0,
                                 0,  5,  3, 63, 63, 64,127,127,128,  0,  3};
    localparam int VK [NV] = '{  3,  2,  1,  0,  3,  2,  0,  1,  2,  3,  0,
                                 3,  3,  0,  1,  0,  0,  2,  0,  0,  0,  1};

    task automatic chk(input string rq, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic poke(input int idx, input logic [7:0] d);
        wr(3'd1, idx[7:0]);
        wr(3'd2, d);
    endtask

    // Present a coordinate, sample one edge later (R10 timing)
    task automatic probe(input string rq, input int x, input int y, input int ek, input int eg);
        @(negedge clk);
        pix_x = x[10:0]; pix_y = y[9:0];
        @(negedge clk);
        chk({rq, " key"}, int'(osd_key), ek);
        chk({rq, " gray"}, int'(osd_gray), eg);
    endtask

    initial begin
        #1_000_000;
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 key after reset", int'(osd_key), 0);
        chk("R1 gray after reset", int'(osd_gray), 0);

        wr(3'd0, 8'h0F);              // target OSD, both shown
        probe("R1 cleared memory", 0, 0, 0, 0);

        poke(0,   8'hE4);
        poke(2,   8'h4C);
        poke(12,  8'h80);
        poke(191, 8'h02);
        poke(192, 8'h6C);
        poke(196, 8'h03);
        poke(255, 8'h01);
        wr(3'd3, 8'h0F);              // R11 small start 1, low bits ignored
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);

        // Table walk: R2 R3 R4 R5 R7 geometry and packing
        for (int i = 0; i < NV; i++) begin
            probe("R2/R3/R4/R5/R7 vector", VX[i], VY[i], VK[i], 0);
        end

        // R10 output changes only at the edge after the coordinate
        @(negedge clk); pix_x = 11'd0; pix_y = 10'd0;
        @(negedge clk);
        pix_x = 11'd24;
        #1;
        chk("R10 held before edge", int'(osd_key), 3);
        @(negedge clk);
        chk("R10 updated after edge", int'(osd_key), 0);

        // R6 show bits
        wr(3'd0, 8'h0B);
        probe("R6 small hidden, wide shows", 64, 0, 1, 0);
        probe("R6 small hidden cell", 72, 0, 0, 0);
        wr(3'd0, 8'h03);
        probe("R6 both hidden", 0, 0, 0, 0);

        // R11 moving bitmaps with low bits set
        wr(3'd0, 8'h0F);
        wr(3'd3, 8'h17);              // small start 2 -> x 128
        wr(3'd5, 8'h1C);              // vertical start 1 -> y 64, mesh off
        probe("R11 moved small origin", 130, 64, 1, 0);
        probe("R11 old spot empty", 130, 0, 0, 0);
        probe("R11 wide moved down", 0, 64, 3, 0);
        wr(3'd3, 8'h08);
        wr(3'd5, 8'h00);

        // R9 mesh
        wr(3'd5, 8'h01);
        probe("R9 gray mesh pixel", 24, 1, 0, 1);
        probe("R9 even parity no mesh", 24, 0, 0, 0);
        probe("R9 cell beats mesh", 64, 0, 1, 0);
        probe("R9 outside no mesh", 500, 1, 0, 0);
        wr(3'd5, 8'h03);
        probe("R9 colour-3 mesh", 24, 1, 3, 0);
        wr(3'd0, 8'h03);
        probe("R9 hidden no mesh", 24, 1, 0, 0);
        wr(3'd5, 8'h00);

        // R8 write target gating and index retention
        wr(3'd0, 8'h0E);
        poke(0, 8'h00);
        probe("R8 ignored write", 0, 0, 3, 0);
        wr(3'd0, 8'h0F);
        wr(3'd2, 8'h40);              // index still 0
        probe("R8 index kept", 0, 0, 1, 0);
        probe("R8 neighbour intact", 8, 0, 0, 0);

        // R1 reset clears control and memory
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 key after second reset", int'(osd_key), 0);
        wr(3'd0, 8'h0F);
        probe("R1 memory cleared by reset", 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule